// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability and Message Generator

This block holds the message-signalled interrupt capability of one endpoint function and converts internal interrupt request pulses into memory-write requests. Configuration software programs a control word, a target address (optionally 64 bits wide), a base data value and a per-vector mask through a simple word-addressed configuration port. Up to 32 request lines feed the block. Each accepted request is folded onto the enabled vector range and recorded as pending. The lowest-numbered unmasked pending vector is then presented as a write request carrying the programmed address and the base data with the vector number in its low bits.

The write request leaves on a valid/ready stream. Once `msg_valid` rises, the address and data are held unchanged until a cycle with `msg_ready` high completes the transfer. A new request may be loaded in that same cycle. Back-pressure only delays delivery. Requests that arrive during a stall are kept as pending bits, one bit per vector, so repeated requests on the same vector merge into one message. The configuration port writes on a clock edge and reads combinationally.

Top module: `msi_msg_gen`

## Requirements
- R1: Word map of the configuration port: 0 control, 1 address low, 2 address high, 3 data, 4 mask, 5 pending; every other word reads 0. After reset the control word reads 0x018A6805 with default parameters: bit 24 is 1, bit 23 is 64-bit capable, bits 22:20 hold the enabled count code (reset 0), bits 19:17 hold the capable count code (parameter, 5), bit 16 is the enable bit, bits 15:8 hold the next pointer (parameter, 0x68) and bits 7:0 hold 0x05. After reset no message is valid and pending reads 0.
- R2: A count code n selects 2^n vectors. A write of an enabled count code greater than the capable code stores the capable code.
- R3: Messages are loaded only while the enable bit is 1. Requests that arrive while it is 0 are dropped, and they leave nothing pending.
- R4: Address bits 1:0 always read 0. When the function is 64-bit capable, `msg_addr` is {address high, address low}. Otherwise the address high word reads 0 and forms the upper half of `msg_addr`.
- R5: Data bits 31:16 always read 0, and `msg_data[31:16]` is 0.
- R6: With 2^n vectors enabled, `msg_data[n-1:0]` holds the vector number and `msg_data[15:n]` holds the programmed data bits 15:n.
- R7: A request on a line at or above the enabled vector count is treated as a request on the highest enabled vector.
- R8: Mask and pending bits exist only for enabled vectors and read 0 above them. Writes to the pending word have no effect.
- R9: A request on a masked vector sets its pending bit and produces no message. When the mask bit is cleared, the message is loaded on the next edge and the pending bit clears on that same edge.
- R10: When several vectors are pending and unmasked, the lowest vector number is sent first, one message per handshake.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R12: A request sampled on an edge becomes pending on that edge. Its message is valid after the following edge, provided the output is free and the vector is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| irq_req | input | 32 | Interrupt request pulses, one per line |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted by downstream |
| msg_addr | output | 64 | Write request address |
| msg_data | output | 32 | Write request data |

## Verification
A request pulse driven before edge A becomes pending at A, and its message appears after edge B, the next edge. The bench therefore checks that `msg_valid` is still low at the falling edge after A and high with the expected data at the falling edge after B. A configuration write takes effect at its edge, so readback is sampled at the following falling edge. After a mask clear, the release is expected one edge later. During a stall, the next message is expected right after the handshake edge. Checks for dropped or masked requests watch `msg_valid` over several cycles and read the pending word before the next stimulus.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int NVEC = 32;
  localparam int VW   = 5;
  localparam logic [7:0] CAP_ID = 8'h05;

  typedef enum logic [2:0] {
    W_CTRL = 3'd0, W_ALO = 3'd1, W_AHI = 3'd2,
    W_DATA = 3'd3, W_MASK = 3'd4, W_PEND = 3'd5
  } word_e;

  typedef struct packed {
    logic        en;
    logic [2:0]  mme;
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [15:0] data;
    logic [31:0] mask;
  } msi_cfg_t;

  function automatic logic [NVEC-1:0] impl_bits(input logic [2:0] code);
    logic [NVEC:0] t;
    t = ({{NVEC{1'b0}}, 1'b1} << (6'd1 << code)) - 1'b1;
    return t[NVEC-1:0];
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter logic [2:0] MMC      = 3'd5,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h68
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [31:0]     wdata,
  input  logic [NVEC-1:0] pend,
  output logic [31:0]     rdata,
  output msi_cfg_t        cfg,
  output logic [NVEC-1:0] impl
);
  logic [2:0] wr_code;

  assign impl    = impl_bits(cfg.mme);
  assign wr_code = (wdata[22:20] > MMC) ? MMC : wdata[22:20];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        W_CTRL: begin
          cfg.mme <= wr_code;
          cfg.en  <= wdata[16];
        end
        W_ALO:  cfg.addr_lo <= {wdata[31:2], 2'b00};
        W_AHI:  if (ADDR64) cfg.addr_hi <= wdata;
        W_DATA: cfg.data <= wdata[15:0];
        W_MASK: cfg.mask <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      W_CTRL:  rdata = {7'b0, 1'b1, ADDR64, cfg.mme, MMC, cfg.en, NEXT_PTR, CAP_ID};
      W_ALO:   rdata = cfg.addr_lo;
      W_AHI:   rdata = cfg.addr_hi;
      W_DATA:  rdata = {16'h0000, cfg.data};
      W_MASK:  rdata = cfg.mask & impl;
      W_PEND:  rdata = pend & impl;
      default: rdata = '0;
    endcase
  end

  a_r2_mme_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mme <= MMC);
  a_r4_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ADDR64 |-> cfg.addr_hi == 32'h0);
endmodule

// File: rtl/msi_vec_sched.sv
module msi_vec_sched
  import msi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_req,
  input  logic            en,
  input  logic [2:0]      mme,
  input  logic [NVEC-1:0] mask,
  input  logic [NVEC-1:0] impl,
  input  logic            take,
  output logic [NVEC-1:0] pend,
  output logic            grant_vld,
  output logic [VW-1:0]   grant_idx
);
  logic [5:0]      cnt;
  logic [NVEC-1:0] onehot [NVEC];
  logic [NVEC-1:0] req_f, eligible, clr, pend_n;

  assign cnt = 6'd1 << mme;

  for (genvar i = 0; i < NVEC; i++) begin : g_fold
    logic [5:0] tgt;
    assign tgt       = (6'(i) >= cnt) ? (cnt - 6'd1) : 6'(i);
    assign onehot[i] = irq_req[i] ? ({{(NVEC-1){1'b0}}, 1'b1} << tgt) : '0;
  end

  always_comb begin
    req_f = '0;
    for (int i = 0; i < NVEC; i++) req_f |= onehot[i];
  end

  assign eligible  = pend & impl & ~mask;
  assign grant_vld = |eligible;

  always_comb begin
    grant_idx = '0;
    for (int i = NVEC - 1; i >= 0; i--) if (eligible[i]) grant_idx = VW'(i);
  end

  assign clr    = take ? ({{(NVEC-1){1'b0}}, 1'b1} << grant_idx) : '0;
  assign pend_n = ((pend & ~clr) | (en ? req_f : '0)) & impl;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_n;
  end

  a_r9_grant_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> !mask[grant_idx]);
  a_r10_no_lower_left: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> ((eligible & ((32'h1 << grant_idx) - 32'h1)) == 32'h0));
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_vld,
  input  logic [VW-1:0] grant_idx,
  input  msi_cfg_t      cfg,
  input  logic          msg_ready,
  output logic          take,
  output logic          msg_valid,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  logic [15:0] low;
  logic [15:0] dat_n;

  assign low   = 16'((17'd1 << cfg.mme) - 17'd1);
  assign dat_n = (cfg.data & ~low) | ({11'b0, grant_idx} & low);
  assign take  = grant_vld && cfg.en && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take) begin
      msg_valid <= 1'b1;
      msg_addr  <= {cfg.addr_hi, cfg.addr_lo};
      msg_data  <= {16'h0000, dat_n};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
  a_r3_load_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && !cfg.en |=> !msg_valid);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[31:16] == 16'h0 && msg_addr[1:0] == 2'b00);
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
#(
  parameter logic [2:0] MMC      = 3'd5,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h68
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] irq_req,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  msi_cfg_t        cfg;
  logic [NVEC-1:0] impl, pend;
  logic            grant_vld, take;
  logic [VW-1:0]   grant_idx;

  msi_cfg_regs #(.MMC(MMC), .ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pend(pend), .rdata(cfg_rdata), .cfg(cfg), .impl(impl)
  );

  msi_vec_sched u_sched (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en(cfg.en), .mme(cfg.mme),
    .mask(cfg.mask), .impl(impl), .take(take), .pend(pend),
    .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  msi_msg_out u_out (
    .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_idx(grant_idx),
    .cfg(cfg), .msg_ready(msg_ready), .take(take), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: tb/sim_msi_msg_gen.sv
`timescale 1ns/1ps
module sim_msi_msg_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, rdata1;
  logic [31:0] irq_req = '0;
  logic        msg_valid, msg_ready = 1'b1, v1;
  logic [63:0] msg_addr, a1;
  logic [31:0] msg_data, d1;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  msi_msg_gen u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  msi_msg_gen #(.ADDR64(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata1), .irq_req(irq_req),
    .msg_valid(v1), .msg_ready(msg_ready), .msg_addr(a1), .msg_data(d1));

  // entry = {count code[2:0], request line[4:0], expected data[15:0]}, base data 0xABCD
  localparam logic [23:0] TBL [10] = '{
    {3'd0, 5'd0,  16'hABCD}, {3'd0, 5'd7,  16'hABCD},
    {3'd1, 5'd0,  16'hABCC}, {3'd1, 5'd1,  16'hABCD},
    {3'd2, 5'd3,  16'hABCF}, {3'd2, 5'd9,  16'hABCF},
    {3'd3, 5'd6,  16'hABCE}, {3'd5, 5'd31, 16'hABDF},
    {3'd5, 5'd17, 16'hABD1}, {3'd4, 5'd20, 16'hABCF}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(tag, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  // pulse at a negedge; pending at edge A, message valid after edge B (R12)
  task automatic fire(input string tag, input logic [31:0] lines, input logic [15:0] exp);
    @(negedge clk); irq_req = lines;
    @(negedge clk); irq_req = '0;
    check({tag, " R12 not early"}, {63'h0, msg_valid}, 64'h0);
    @(negedge clk);
    check({tag, " R12 valid"}, {63'h0, msg_valid}, 64'h1);
    check({tag, " data"}, {32'h0, msg_data}, {48'h0, exp});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl reset", 3'd0, 32'h018A6805);
    rd("R1 pend reset", 3'd5, 32'h0);
    rd("R1 unused word", 3'd7, 32'h0);
    check("R1 no msg", {63'h0, msg_valid}, 64'h0);
    // R2 saturation
    wr(3'd0, 32'h0071_0000);
    rd("R2 saturate", 3'd0, 32'h01DB6805);
    // R4 / R5 register behaviour
    wr(3'd1, 32'hFEE0_0003);
    wr(3'd2, 32'h1234_5678);
    wr(3'd3, 32'hFFFF_ABCD);
    rd("R4 low bits", 3'd1, 32'hFEE00000);
    rd("R4 hi 64b", 3'd2, 32'h12345678);
    cfg_addr = 3'd2; #1;
    check("R4 hi reads 0 when 32b", {32'h0, rdata1}, 64'h0);
    rd("R5 data upper", 3'd3, 32'h0000ABCD);

    // table walk: R6 folding and R7 out-of-range mapping
    for (int i = 0; i < 10; i++) begin
      wr(3'd0, {9'h0, TBL[i][23:21], 4'h1, 16'h0});
      fire($sformatf("R6 R7 entry %0d", i), 32'h1 << TBL[i][20:16], TBL[i][15:0]);
      check("R5 upper zero", {48'h0, msg_data[31:16]}, 64'h0);
    end
    check("R4 msg_addr", msg_addr, 64'h12345678_FEE00000);
    @(negedge clk);
    check("R11 consumed", {63'h0, msg_valid}, 64'h0);

    // R3 disabled drops requests
    wr(3'd0, 32'h0020_0000);
    @(negedge clk); irq_req = 32'h1;
    @(negedge clk); irq_req = '0;
    repeat (3) @(negedge clk);
    check("R3 no msg disabled", {63'h0, msg_valid}, 64'h0);
    rd("R3 nothing pending", 3'd5, 32'h0);
    wr(3'd0, 32'h0021_0000);
    repeat (2) @(negedge clk);
    check("R3 dropped stays dropped", {63'h0, msg_valid}, 64'h0);

    // R8 mask bits above enabled read 0, pending writes ignored
    wr(3'd4, 32'hFFFF_FFFF);
    rd("R8 mask width", 3'd4, 32'h0000000F);
    wr(3'd5, 32'hFFFF_FFFF);
    rd("R8 pend write ignored", 3'd5, 32'h0);

    // R9 masked request pends, release on mask clear
    wr(3'd4, 32'h0000_0004);
    @(negedge clk); irq_req = 32'h4;
    @(negedge clk); irq_req = '0;
    repeat (2) @(negedge clk);
    check("R9 masked no msg", {63'h0, msg_valid}, 64'h0);
    rd("R9 pending set", 3'd5, 32'h4);
    wr(3'd4, 32'h0);
    check("R9 not before release edge", {63'h0, msg_valid}, 64'h0);
    @(negedge clk);
    check("R9 released", {63'h0, msg_valid}, 64'h1);
    check("R9 released data", {32'h0, msg_data}, 64'hABCE);
    rd("R9 pending cleared", 3'd5, 32'h0);
    @(negedge clk);

    // R10 arbitration with R11 back-pressure
    wr(3'd0, 32'h0031_0000);
    msg_ready = 1'b0;
    @(negedge clk); irq_req = 32'h24;
    @(negedge clk); irq_req = '0;
    @(negedge clk);
    check("R10 first lowest", {32'h0, msg_data}, 64'hABCA);
    @(negedge clk);
    check("R11 held valid", {63'h0, msg_valid}, 64'h1);
    check("R11 held data", {32'h0, msg_data}, 64'hABCA);
    msg_ready = 1'b1;
    @(negedge clk);
    check("R10 second valid", {63'h0, msg_valid}, 64'h1);
    check("R10 second data", {32'h0, msg_data}, 64'hABCD);
    @(negedge clk);
    check("R10 drained", {63'h0, msg_valid}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule